// File: doc/BRIEF.md
# Write-Completion Status Readback

This block sits in the read path of a byte-wide non-volatile memory model and decides what a host read returns while an internal programming cycle is running. A read is qualified when chip enable and output enable are both low and write enable is high. Outside programming, a qualified read returns the array data for the addressed byte. While the write controller holds its busy flag, the read byte carries two completion indicators. Bit 7 is an inverted copy of the last written byte's bit 7. Bit 6 changes value on every new read.

A host can therefore learn that a write has finished in either of two ways. It can re-read the last written address until bit 7 matches what it wrote. Or it can read any address twice and wait for bit 6 to stop changing. The block owns the tri-state enable for the data bus. The write sequencing and the write protection live elsewhere: a write that protection rejects never raises busy, so polling stays inactive for it. The bus output is registered, so a read's data appears one clock after the read is qualified.

Top module: `wr_status_readback`

## Requirements
- R1: One clock after a cycle in which chip enable is high, output enable is high, or write enable is low, the bus enable output is 0. One clock after a cycle in which all three qualify a read, it is 1.
- R2: With busy low, a qualified read presents the array data byte, sampled in the previous cycle, on all 8 bits.
- R3: With busy high and the read address equal to the last written address, bit 7 of the read byte is the inverse of bit 7 of the last written byte.
- R4: With busy high and the read address equal to the last written address, bits 5 to 0 of the read byte equal bits 5 to 0 of the last written byte.
- R5: With busy high, bit 6 of each new read (a new assertion of read qualification) is the inverse of bit 6 in the previous read, at any address.
- R6: Bit 6 holds a constant value for as long as one read stays qualified.
- R7: With busy high and a read address other than the last written address, bits 7 and 5 to 0 come from the array data.
- R8: Once busy is low, reads return true array data on all bits, including at the last written address, and bit 6 no longer alternates.
- R9: During and right after reset, the bus enable is 0 and the read byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEnN | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Output enable, active low |
| wrEnN | input | 1 | Write enable, active low |
| rdAddr | input | ADDR_W (17) | Read address |
| arrayData | input | DATA_W (8) | Array contents at rdAddr |
| busy | input | 1 | Programming cycle in progress |
| lastAddr | input | ADDR_W (17) | Address of the last accepted write |
| lastData | input | DATA_W (8) | Data of the last accepted write |
| busData | output | DATA_W (8) | Byte driven onto the data bus |
| busOe | output | 1 | Tri-state enable for the data bus |

## Verification
A wrong toggle state shows on the second read of a programming cycle: bit 6 repeats instead of alternating, or it changes in the middle of a held read. A wrong address-match or busy decision shows one clock after the read is qualified. Either bit 7 fails to invert at the last written address, or status bits leak into reads of other addresses or into reads after busy falls. The directed reads each check the byte on the clock after qualification and the bus release on the clock after the read ends. Any such fault is therefore visible within two clocks of the read that exposes it.

// File: rtl/rd_status_pkg.sv
package rd_status_pkg;
  // Strobes handed from the control half to the datapath each cycle.
  typedef struct packed {
    logic rdActive;   // read qualified this cycle
    logic rdStart;    // first cycle of a qualified read
    logic pollMode;   // programming cycle in progress
    logic addrHit;    // read address equals last written address
    logic toggleBit;  // toggle value to present for this read
  } rdStrobe_t;
endpackage

// File: rtl/rd_status_ctrl.sv
module rd_status_ctrl
  import rd_status_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] lastAddr,
  output rdStrobe_t         strb
);
  logic rdQual;
  logic rdPrev;
  logic toggleQ;
  logic toggleNext;

  assign rdQual     = !chipEnN && !outEnN && wrEnN;
  assign toggleNext = (rdQual && !rdPrev && busy) ? !toggleQ : toggleQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev  <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      rdPrev  <= rdQual;
      toggleQ <= toggleNext;
    end
  end

  always_comb begin
    strb.rdActive  = rdQual;
    strb.rdStart   = rdQual && !rdPrev;
    strb.pollMode  = busy;
    strb.addrHit   = (rdAddr == lastAddr);
    strb.toggleBit = toggleNext;
  end

  // R5: a read starting during programming moves the toggle state
  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStart && busy) |=> (toggleQ != $past(toggleQ)));

  // R6: the toggle state stays put while one read stays qualified
  p_toggle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdQual && rdPrev) |=> $stable(toggleQ));

  // R8: no programming, no toggle movement
  p_toggle_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(toggleQ));
endmodule

// File: rtl/rd_status_dp.sv
module rd_status_dp
  import rd_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] lastData,
  output logic [DATA_W-1:0] busData,
  output logic              busOe
);
  localparam int POLL_IDX = DATA_W - 1;
  localparam int TOG_IDX  = DATA_W - 2;

  logic [DATA_W-1:0] nextData;

  always_comb begin
    nextData = arrayData;
    if (strb.pollMode && strb.addrHit) begin
      nextData           = lastData;
      nextData[POLL_IDX] = !lastData[POLL_IDX];
    end
    if (strb.pollMode) nextData[TOG_IDX] = strb.toggleBit;
    if (!strb.rdActive) nextData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busData <= '0;
      busOe   <= 1'b0;
    end else begin
      busData <= nextData;
      busOe   <= strb.rdActive;
    end
  end

  // R9: an idle bus carries zero data
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busData == '0));
endmodule

// File: rtl/wr_status_readback.sv
module wr_status_readback
  import rd_status_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              busy,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic [DATA_W-1:0] lastData,
  output logic [DATA_W-1:0] busData,
  output logic              busOe
);
  localparam int POLL_IDX = DATA_W - 1;
  localparam int LOW_W    = DATA_W - 2;

  rdStrobe_t strb;

  rd_status_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .wrEnN(wrEnN), .busy(busy), .rdAddr(rdAddr), .lastAddr(lastAddr),
    .strb(strb)
  );

  rd_status_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .arrayData(arrayData),
    .lastData(lastData), .busData(busData), .busOe(busOe)
  );

  // R1: bus released one clock after any disqualifying pin state
  p_hiz_r1: assert property (@(posedge clk) disable iff (!rstN)
    (chipEnN || outEnN || !wrEnN) |=> !busOe);

  // R2: reads outside programming return the array byte
  p_true_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !outEnN && wrEnN && !busy) |=> (busData == $past(arrayData)));

  // R3: polling bit inverted at the last written address
  p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !outEnN && wrEnN && busy && rdAddr == lastAddr)
      |=> (busData[POLL_IDX] != $past(lastData[POLL_IDX])));

  // R4: low bits follow the last written byte during polling
  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !outEnN && wrEnN && busy && rdAddr == lastAddr)
      |=> (busData[LOW_W-1:0] == $past(lastData[LOW_W-1:0])));
endmodule

// File: tb/wr_status_readback_tb_top.sv
module wr_status_readback_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          chipEnN, outEnN, wrEnN, busy;
  logic [AW-1:0] rdAddr, lastAddr;
  logic [DW-1:0] arrayData, lastData;
  logic [DW-1:0] busData;
  logic          busOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit togValid = 0;
  logic togPrev = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] memOf(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA6;
  endfunction
  assign arrayData = memOf(rdAddr);

  wr_status_readback #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .wrEnN(wrEnN), .rdAddr(rdAddr), .arrayData(arrayData), .busy(busy),
    .lastAddr(lastAddr), .lastData(lastData), .busData(busData), .busOe(busOe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One qualified read held for 'hold' cycles; returns the byte seen.
  task automatic doRead(input logic [AW-1:0] a, input int hold, output logic [DW-1:0] d);
    @(negedge clk);
    rdAddr = a; chipEnN = 1'b0; outEnN = 1'b0; wrEnN = 1'b1;
    @(negedge clk);
    chk(busOe == 1'b1, "R1 enable during read", busOe, 1);
    d = busData;
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      chk(busData[6] == d[6], "R6 toggle steady in read", busData[6], d[6]);
    end
    chipEnN = 1'b1; outEnN = 1'b1;
    @(negedge clk);
    chk(busOe == 1'b0, "R1 release after read", busOe, 0);
  endtask

  task automatic expectToggle(input logic b);
    if (togValid) chk(b == !togPrev, "R5 toggle alternates", b, !togPrev);
    togPrev = b; togValid = 1;
  endtask

  task automatic testReset();
    rstN = 1'b0; chipEnN = 1'b0; outEnN = 1'b0; wrEnN = 1'b1;
    busy = 1'b0; rdAddr = '0; lastAddr = '0; lastData = '0;
    repeat (3) @(negedge clk);
    chk(busOe == 1'b0, "R9 enable in reset", busOe, 0);
    chk(busData == '0, "R9 data in reset", busData, 0);
    chipEnN = 1'b1; outEnN = 1'b1;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(busOe == 1'b0, "R9 enable after reset", busOe, 0);
    chk(busData == '0, "R9 data after reset", busData, 0);
  endtask

  task automatic testIdleReads();
    logic [DW-1:0] d;
    logic [AW-1:0] addrs [3] = '{17'h00000, 17'h15555, 17'h1FFFF};
    foreach (addrs[k]) begin
      doRead(addrs[k], 2, d);
      chk(d == memOf(addrs[k]), "R2 idle read data", d, memOf(addrs[k]));
    end
  endtask

  task automatic testDisqualified();
    @(negedge clk);
    chipEnN = 1'b0; outEnN = 1'b0; wrEnN = 1'b0; rdAddr = 17'h00123;
    @(negedge clk);
    chk(busOe == 1'b0, "R1 write enable low blocks read", busOe, 0);
    wrEnN = 1'b1; chipEnN = 1'b1;
    @(negedge clk);
    chk(busOe == 1'b0, "R1 chip enable high", busOe, 0);
    chipEnN = 1'b0; outEnN = 1'b1;
    @(negedge clk);
    chk(busOe == 1'b0, "R1 output enable high", busOe, 0);
    chipEnN = 1'b1;
  endtask

  task automatic testPollMatch();
    logic [DW-1:0] d;
    logic [DW-1:0] vals [2] = '{8'h35, 8'hCA};
    busy = 1'b1; lastAddr = 17'h02AAA; togValid = 0;
    foreach (vals[k]) begin
      lastData = vals[k];
      for (int r = 0; r < 2; r++) begin
        doRead(lastAddr, 3, d);
        chk(d[7] == !vals[k][7], "R3 bit7 inverted", d[7], !vals[k][7]);
        chk(d[5:0] == vals[k][5:0], "R4 low bits from last write", d[5:0], vals[k][5:0]);
        expectToggle(d[6]);
      end
    end
  endtask

  task automatic testPollOther();
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    for (int r = 0; r < 3; r++) begin
      a = 17'h10F00 + AW'(r * 7);
      doRead(a, 1, d);
      chk(d[7] == memOf(a)[7], "R7 bit7 from array", d[7], memOf(a)[7]);
      chk(d[5:0] == memOf(a)[5:0], "R7 low bits from array", d[5:0], memOf(a)[5:0]);
      expectToggle(d[6]);
    end
  endtask

  task automatic testDone();
    logic [DW-1:0] d;
    @(negedge clk); busy = 1'b0;
    for (int r = 0; r < 3; r++) begin
      doRead(lastAddr, 2, d);
      chk(d == memOf(lastAddr), "R8 true data after busy", d, memOf(lastAddr));
    end
    doRead(17'h00777, 1, d);
    chk(d == memOf(17'h00777), "R8 other address after busy", d, memOf(17'h00777));
    // busy back high: toggle resumes from a held state, no hidden advance
    @(negedge clk); busy = 1'b1;
    doRead(lastAddr, 1, d);
    chk(d[6] == !togPrev, "R8 toggle frozen while idle", d[6], !togPrev);
    busy = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testIdleReads();
    testDisqualified();
    testPollMatch();
    testPollOther();
    testDone();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule